// File: doc/BRIEF.md
# Endian-selectable bus lane steering unit

This unit sits between a 32-bit internal bus and an external data bus whose device may be 8, 16 or 32 bits wide. It accepts one byte, word or longword request at a time. It breaks the request into one or more external accesses and places each byte of the value on the correct data lane. On reads, it rebuilds the internal value from the lanes that come back.

Lane order is big-endian by default. A configuration bit can switch one designated region, chosen by the `LE_REGION` parameter, to little-endian order. A request that targets any other region stays big-endian even if that bit is set.

Each external access is presented with a valid signal. It is held until the external side acknowledges it. A read that spans several accesses is gathered in a register and returned as one result, together with a single-cycle done pulse. Strobe shaping, wait-state generation and chip-select decoding are handled elsewhere.

Top module: `lane_steer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `ext_valid` are low.
- R2: A request uses little-endian order only when `req_region` equals `LE_REGION` (default 2) and `le_enable` is 1. Every other request uses big-endian order.
- R3: Size codes are 0 = byte, 1 = word and 2 = longword (3 acts as longword). Width codes are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit (3 acts as 32-bit). With S request bytes and W device bytes, the unit issues S/W accesses at addresses A, A+W, ... when S > W, and otherwise issues one access at address A.
- R4: Lane 0 is bits 7..0. For a byte at address a, big-endian order uses lane W-1-(a mod W) and little-endian order uses lane a mod W. In big-endian order the lowest address holds the most significant value byte; in little-endian order it holds the least significant.
- R5: On a write access, `ext_write` is 1. `ext_lane_we` has a 1 exactly on the lanes that carry requested bytes, and those lanes carry the bytes given by R4.
- R6: On a read access, `ext_write` is 0 and `ext_lane_we` is 0, so the full device width is fetched. `rdata` is right-justified with its upper bytes zero. Lanes at or above the device width have no effect on `rdata`.
- R7: Read data from a split access is held until the last access completes. `rdata` then holds the whole value and `done` pulses for exactly one cycle, one cycle after the final acknowledge.
- R8: A request is accepted only when `busy` is 0. `busy` is high from the cycle after acceptance until the `done` cycle. A request offered while busy has no effect.
- R9: While `ext_valid` is 1 and `ext_ack` is 0, the next cycle still has `ext_valid` high with the same address, write data, lane enables and direction.
- R10: Address bits below the request size are ignored. A longword at address 6 is issued as a longword at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Request size code |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | 32 | Write value, right-justified |
| req_region | input | REGION_W | Region index of the request |
| dev_width | input | 2 | Device width code of the region |
| le_enable | input | 1 | Little-endian enable for the designated region |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read value |
| ext_valid | output | 1 | External access presented |
| ext_write | output | 1 | External access direction |
| ext_addr | output | ADDR_W | External access address |
| ext_wdata | output | 32 | Lane-steered write data |
| ext_lane_we | output | 4 | Per-lane write enables |
| ext_ack | input | 1 | External access completes this cycle |
| ext_rdata | input | 32 | Lanes returned by the device |

## Verification
A request is accepted on a clock edge. `busy`, `ext_valid` and the first address are due one cycle after that edge. Each access retires on the edge at which `ext_ack` is high, and the next address is due one cycle later. `done` and the final `rdata` are due exactly one cycle after the last acknowledge, and `done` falls one cycle after that. The bench drives inputs and samples outputs on the falling edge, so every check reads a value that the preceding rising edge has settled. The acknowledge latency varies from zero to two cycles, which tests both back-to-back retirement and held accesses.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

   localparam int unsigned BUS_W = 32;
   localparam int unsigned LANES = BUS_W / 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;

   typedef enum logic [1:0] {
      DW_8    = 2'd0,
      DW_16   = 2'd1,
      DW_32   = 2'd2,
      DW_RSVD = 2'd3
   } dev_width_e;

   typedef struct packed {
      logic             write;
      logic [1:0]       size;
      logic [1:0]       width;
      logic             le;
      logic [BUS_W-1:0] wdata;
   } xfer_t;

   typedef struct packed {
      logic       hit;
      logic [1:0] vbyte;
   } lane_map_t;

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: return 3'd1;
         SZ_WORD: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [2:0] width_bytes(input logic [1:0] wd);
      case (wd)
         DW_8:    return 3'd1;
         DW_16:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [1:0] width_shift(input logic [1:0] wd);
      case (wd)
         DW_8:    return 2'd0;
         DW_16:   return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

   // Which value byte, if any, a device lane carries in the current beat.
   function automatic lane_map_t map_lane(
      input logic [1:0] lane,
      input logic [1:0] beat_lo,
      input logic [1:0] req_lo,
      input logic [1:0] sz,
      input logic [1:0] wd,
      input logic       le
   );
      logic [2:0] wb, sb, base, off, a, k, v;
      lane_map_t  m;
      wb   = width_bytes(wd);
      sb   = size_bytes(sz);
      base = {1'b0, beat_lo} & ~(wb - 3'd1);
      off  = le ? {1'b0, lane} : (wb - 3'd1 - {1'b0, lane});
      a    = base + off;
      k    = a - {1'b0, req_lo};
      v    = le ? k : (sb - 3'd1 - k);
      m.hit   = ({1'b0, lane} < wb) && (a >= {1'b0, req_lo}) && (k < sb);
      m.vbyte = v[1:0];
      return m;
   endfunction

endpackage

// File: rtl/lane_steer_seq.sv
module lane_steer_seq
   import lane_steer_pkg::*;
#(
   parameter int unsigned ADDR_W = 27
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  xfer_t             req_xfer,
   input  logic              ext_ack,
   output logic              busy,
   output logic              done,
   output logic              beat_ack,
   output logic [ADDR_W-1:0] beat_addr,
   output logic [1:0]        base_lo,
   output xfer_t             xfer_q
);

   logic [2:0]        sb_in, wb_in;
   logic [1:0]        ws_in, last_in;
   logic [ADDR_W-1:0] addr_al;

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        beat_q, last_q, ws_q;
   logic              busy_q, done_q;

   assign sb_in   = size_bytes(req_xfer.size);
   assign wb_in   = width_bytes(req_xfer.width);
   assign ws_in   = width_shift(req_xfer.width);
   assign last_in = (sb_in > wb_in) ? 2'((sb_in >> ws_in) - 3'd1) : 2'd0;
   assign addr_al = req_addr & ~ADDR_W'(sb_in - 3'd1);

   assign busy      = busy_q;
   assign done      = done_q;
   assign beat_ack  = busy_q && ext_ack;
   assign beat_addr = base_q + (ADDR_W'(beat_q) << ws_q);
   assign base_lo   = base_q[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         beat_q <= '0;
         last_q <= '0;
         ws_q   <= '0;
         base_q <= '0;
         xfer_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         beat_q <= '0;
         last_q <= last_in;
         ws_q   <= ws_in;
         base_q <= addr_al;
         xfer_q <= req_xfer;
      end else begin
         done_q <= 1'b0;
         if (beat_ack) begin
            if (beat_q == last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               beat_q <= beat_q + 2'd1;
            end
         end
      end
   end

endmodule

// File: rtl/lane_steer_wr.sv
module lane_steer_wr
   import lane_steer_pkg::*;
(
   input  logic             active,
   input  xfer_t            xfer,
   input  logic [1:0]       req_lo,
   input  logic [1:0]       beat_lo,
   output logic [LANES-1:0] lane_we,
   output logic [BUS_W-1:0] lane_data
);

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      lane_map_t m;
      assign m = map_lane(2'(gl), beat_lo, req_lo, xfer.size, xfer.width, xfer.le);
      assign lane_we[gl] = active && xfer.write && m.hit;
      assign lane_data[8*gl +: 8] = m.hit ? xfer.wdata[{m.vbyte, 3'b000} +: 8] : 8'h00;
   end

endmodule

// File: rtl/lane_steer_rd.sv
module lane_steer_rd
   import lane_steer_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             capture,
   input  logic             is_write,
   input  logic [1:0]       size,
   input  logic [1:0]       width,
   input  logic             le,
   input  logic [1:0]       req_lo,
   input  logic [1:0]       beat_lo,
   input  logic [BUS_W-1:0] ext_rdata,
   output logic [BUS_W-1:0] rdata
);

   logic [BUS_W-1:0] acc_q, merged;
   lane_map_t        maps [LANES];

   for (genvar gl = 0; gl < LANES; gl++) begin : g_map
      assign maps[gl] = map_lane(2'(gl), beat_lo, req_lo, size, width, le);
   end

   always_comb begin
      merged = acc_q;
      for (int l = 0; l < LANES; l++) begin
         if (maps[l].hit) merged[{maps[l].vbyte, 3'b000} +: 8] = ext_rdata[8*l +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    acc_q <= '0;
      else if (clear)                acc_q <= '0;
      else if (capture && !is_write) acc_q <= merged;
   end

   assign rdata = acc_q;

endmodule

// File: rtl/lane_steer.sv
module lane_steer
   import lane_steer_pkg::*;
#(
   parameter  int unsigned ADDR_W      = 27,
   parameter  int unsigned NUM_REGIONS = 4,
   parameter  int unsigned LE_REGION   = 2,
   localparam int unsigned REGION_W    = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [1:0]          req_size,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [31:0]         req_wdata,
   input  logic [REGION_W-1:0] req_region,
   input  logic [1:0]          dev_width,
   input  logic                le_enable,
   output logic                busy,
   output logic                done,
   output logic [31:0]         rdata,
   output logic                ext_valid,
   output logic                ext_write,
   output logic [ADDR_W-1:0]   ext_addr,
   output logic [31:0]         ext_wdata,
   output logic [3:0]          ext_lane_we,
   input  logic                ext_ack,
   input  logic [31:0]         ext_rdata
);

   initial begin : param_checks
      if (ADDR_W < 3)               $fatal(1, "lane_steer: ADDR_W must be at least 3");
      if (NUM_REGIONS < 1)          $fatal(1, "lane_steer: NUM_REGIONS must be at least 1");
      if (LE_REGION >= NUM_REGIONS) $fatal(1, "lane_steer: LE_REGION outside region range");
      if (BUS_W != 32)              $fatal(1, "lane_steer: internal bus must be 32 bits");
   end

   logic        accept, le_eff, beat_ack;
   logic [1:0]  size_n, width_n, base_lo;
   xfer_t       req_x, xfer_q;
   logic [ADDR_W-1:0] beat_addr;

   assign accept  = req_valid && !busy;
   assign le_eff  = le_enable && (req_region == REGION_W'(LE_REGION));
   assign size_n  = (req_size  == SZ_RSVD) ? SZ_LONG : req_size;
   assign width_n = (dev_width == DW_RSVD) ? DW_32   : dev_width;
   assign req_x   = '{write: req_write, size: size_n, width: width_n, le: le_eff, wdata: req_wdata};

   lane_steer_seq #(.ADDR_W(ADDR_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_xfer  (req_x),
      .ext_ack   (ext_ack),
      .busy      (busy),
      .done      (done),
      .beat_ack  (beat_ack),
      .beat_addr (beat_addr),
      .base_lo   (base_lo),
      .xfer_q    (xfer_q)
   );

   lane_steer_wr i_wr (
      .active    (busy),
      .xfer      (xfer_q),
      .req_lo    (base_lo),
      .beat_lo   (beat_addr[1:0]),
      .lane_we   (ext_lane_we),
      .lane_data (ext_wdata)
   );

   lane_steer_rd i_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .capture   (beat_ack),
      .is_write  (xfer_q.write),
      .size      (xfer_q.size),
      .width     (xfer_q.width),
      .le        (xfer_q.le),
      .req_lo    (base_lo),
      .beat_lo   (beat_addr[1:0]),
      .ext_rdata (ext_rdata),
      .rdata     (rdata)
   );

   assign ext_valid = busy;
   assign ext_write = busy && xfer_q.write;
   assign ext_addr  = beat_addr;

endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
   parameter int unsigned ADDR_W = 27
)(
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              ext_valid,
   input logic              ext_write,
   input logic              ext_ack,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [31:0]       ext_wdata,
   input logic [3:0]        ext_lane_we
);

   assert_quiet_in_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done && !ext_valid));

   assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(ext_valid && ext_ack));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !ext_valid));

   assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && !ext_ack) |=> (ext_valid && $stable(ext_addr) && $stable(ext_wdata)
                                   && $stable(ext_lane_we) && $stable(ext_write)));

   assert_read_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && !ext_write) |-> (ext_lane_we == 4'b0000));

   assert_write_has_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_valid && ext_write) |-> (ext_lane_we != 4'b0000));

endmodule

bind lane_steer lane_steer_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .ext_valid   (ext_valid),
   .ext_write   (ext_write),
   .ext_ack     (ext_ack),
   .ext_addr    (ext_addr),
   .ext_wdata   (ext_wdata),
   .ext_lane_we (ext_lane_we)
);

// File: tb/test_lane_steer.sv
module test_lane_steer;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 27;
   localparam int LE_REGION  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_write = 1'b0, le_enable = 1'b0;
   logic [1:0]        req_size = '0, dev_width = '0, req_region = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic              busy, done, ext_valid, ext_write;
   logic [31:0]       rdata, ext_wdata;
   logic [ADDR_W-1:0] ext_addr;
   logic [3:0]        ext_lane_we;
   logic              ext_ack = 1'b0;
   logic [31:0]       ext_rdata = '0;

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 0;

   logic [7:0]  lmem [0:7][0:3];
   logic [31:0] b_addr [0:7];
   logic [3:0]  b_we   [0:7];
   logic [31:0] b_wd   [0:7];
   logic        b_wr   [0:7];
   int          b_n;
   logic [31:0] got_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_steer #(.ADDR_W(ADDR_W), .NUM_REGIONS(4), .LE_REGION(LE_REGION)) i_lane_steer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_region(req_region), .dev_width(dev_width), .le_enable(le_enable),
      .busy(busy), .done(done), .rdata(rdata), .ext_valid(ext_valid),
      .ext_write(ext_write), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
      .ext_lane_we(ext_lane_we), .ext_ack(ext_ack), .ext_rdata(ext_rdata)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int wbytes(input logic [1:0] wid);
      return (wid == 2'd0) ? 1 : (wid == 2'd1) ? 2 : 4;
   endfunction

   function automatic int sbytes(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 8; i++)
         for (int l = 0; l < 4; l++) lmem[i][l] = 8'h00;
   endtask

   // One request: handshake, device model with lat wait cycles per access.
   task automatic run_req(input bit wr, input logic [1:0] sz, input int addr, input logic [31:0] v,
                          input int region, input bit le_in, input logic [1:0] wid,
                          input int lat, input bit poke);
      int wb;
      int idx;
      logic [31:0] first_addr;
      wb = wbytes(wid);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ADDR_W'(addr);
      req_wdata = v; req_region = 2'(region); le_enable = le_in; dev_width = wid;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         req_valid = 1'b1; req_write = !wr; req_addr = ADDR_W'(addr + 16); req_size = 2'd0;
      end
      check("R8", "busy after accept", 32'(busy), 32'd1);
      b_n = 0;
      while (ext_valid && b_n < 8) begin
         first_addr = 32'(ext_addr);
         check("R8", "busy during access", 32'(busy), 32'd1);
         for (int w = 0; w < lat; w++) begin
            ext_ack = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
            check("R9", "address held until ack", 32'(ext_addr), first_addr);
         end
         ext_ack = 1'b1;
         b_addr[b_n] = 32'(ext_addr);
         b_we[b_n]   = ext_lane_we;
         b_wd[b_n]   = ext_wdata;
         b_wr[b_n]   = ext_write;
         idx = int'(ext_addr) / wb;
         for (int l = 0; l < 4; l++) begin
            if (l < wb && idx < 8) begin
               ext_rdata[8*l +: 8] = lmem[idx][l];
               if (ext_lane_we[l]) lmem[idx][l] = ext_wdata[8*l +: 8];
            end else begin
               ext_rdata[8*l +: 8] = 8'hEE;
            end
         end
         @(negedge clk);
         ext_ack = 1'b0;
         req_valid = 1'b0;
         b_n++;
      end
      check("R7", "done after final ack", 32'(done), 32'd1);
      check("R8", "busy low at done", 32'(busy), 32'd0);
      got_rdata = rdata;
      @(negedge clk);
      check("R7", "done lasts one cycle", 32'(done), 32'd0);
   endtask

   // Compare recorded accesses with the arithmetic model of R3..R6.
   task automatic check_beats(input bit wr, input logic [1:0] sz, input int addr, input logic [31:0] v,
                              input bit le, input logic [1:0] wid);
      int sb, wb, nexp, ea, b, o, a, k, vb;
      logic [3:0]  ewe;
      logic [31:0] ewd, mask;
      sb = sbytes(sz);
      wb = wbytes(wid);
      nexp = (sb > wb) ? sb / wb : 1;
      check("R3", "access count", 32'(b_n), 32'(nexp));
      for (int j = 0; j < nexp && j < b_n; j++) begin
         ea = (sb > wb) ? addr + j * wb : addr;
         check("R3", "access address", b_addr[j], 32'(ea));
         if (wr) begin
            ewe = '0; ewd = '0; mask = '0;
            b = ea - (ea % wb);
            for (int l = 0; l < wb; l++) begin
               o = le ? l : wb - 1 - l;
               a = b + o;
               if (a >= addr && a < addr + sb) begin
                  k  = a - addr;
                  vb = le ? k : sb - 1 - k;
                  ewe[l] = 1'b1;
                  ewd[8*l +: 8] = v[8*vb +: 8];
                  mask[8*l +: 8] = 8'hFF;
               end
            end
            check("R5", "write direction", 32'(b_wr[j]), 32'd1);
            check("R5", "lane enables", 32'(b_we[j]), 32'(ewe));
            check("R4", "write lane data", b_wd[j] & mask, ewd);
         end else begin
            check("R6", "read direction", 32'(b_wr[j]), 32'd0);
            check("R6", "no lane enables on read", 32'(b_we[j]), 32'd0);
         end
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_errs++;
         $display("FAIL R8 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, mask;
      int iter;
      int sb;
      int region;
      bit le_in, le_eff;
      iter = 0;
      clear_mem();
      @(negedge clk);
      @(negedge clk);
      check("R1", "busy in reset", 32'(busy), 32'd0);
      check("R1", "done in reset", 32'(done), 32'd0);
      check("R1", "ext_valid in reset", 32'(ext_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "ext_valid after reset", 32'(ext_valid), 32'd0);

      // R2: endian bit ignored outside the designated region
      run_req(1'b1, 2'd0, 0, 32'h0000005A, 0, 1'b1, 2'd1, 0, 1'b0);
      check("R2", "byte 0 on 16-bit, other region", 32'(b_we[0]), 32'h2);
      check("R2", "byte 0 lane data, other region", 32'(b_wd[0][15:8]), 32'h5A);
      run_req(1'b1, 2'd0, 0, 32'h0000005A, LE_REGION, 1'b1, 2'd1, 0, 1'b0);
      check("R2", "byte 0 on 16-bit, designated region", 32'(b_we[0]), 32'h1);
      run_req(1'b1, 2'd0, 1, 32'h000000C7, LE_REGION, 1'b0, 2'd1, 1, 1'b0);
      check("R2", "designated region with bit clear", 32'(b_we[0]), 32'h1);

      // R4: halfword order of a split longword
      run_req(1'b1, 2'd2, 0, 32'h11223344, LE_REGION, 1'b1, 2'd1, 0, 1'b0);
      check("R4", "LE first half", 32'(b_wd[0][15:0]), 32'h3344);
      check("R4", "LE second half", 32'(b_wd[1][15:0]), 32'h1122);
      run_req(1'b1, 2'd2, 0, 32'h11223344, 1, 1'b1, 2'd1, 2, 1'b0);
      check("R4", "BE first half", 32'(b_wd[0][15:0]), 32'h1122);

      // R10: low address bits below the size are ignored
      run_req(1'b0, 2'd2, 6, 32'h0, 0, 1'b0, 2'd1, 0, 1'b0);
      check("R10", "misaligned long first address", b_addr[0], 32'd4);
      check("R10", "misaligned long second address", b_addr[1], 32'd6);

      // Sweep: width x endian configuration x size x aligned address
      for (int wi = 0; wi < 3; wi++) begin
         clear_mem();
         for (int cfg = 0; cfg < 3; cfg++) begin
            region = (cfg == 1) ? 1 : LE_REGION;
            le_in  = (cfg != 2);
            le_eff = (cfg == 0);
            for (int si = 0; si < 3; si++) begin
               sb = sbytes(2'(si));
               for (int a = 0; a < 8; a += sb) begin
                  iter++;
                  v = 32'hC3A55A3C ^ (32'(iter) * 32'h01030507);
                  mask = (sb == 1) ? 32'h000000FF : (sb == 2) ? 32'h0000FFFF : 32'hFFFFFFFF;
                  run_req(1'b1, 2'(si), a, v, region, le_in, 2'(wi), (a + si) % 3, (a % 3) == 1);
                  check_beats(1'b1, 2'(si), a, v, le_eff, 2'(wi));
                  run_req(1'b0, 2'(si), a, 32'hFFFFFFFF, region, le_in, 2'(wi), (a + si + 1) % 3, (a % 3) == 2);
                  check_beats(1'b0, 2'(si), a, v, le_eff, 2'(wi));
                  if (si == 2 && wi < 2)
                     check("R7", "split read assembled", got_rdata, v & mask);
                  else
                     check("R6", "read value right-justified", got_rdata, v & mask);
               end
            end
         end
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule